// File: doc/BRIEF.md
# Priority Interrupt Controller

This block collects up to `N` interrupt request lines into one registered interrupt output for a processor. Software reaches it over a plain 32-bit register bus: an address, write data, a write strobe and a read strobe, with read data returned the cycle after the read strobe. A pending register records requests and a mask register selects which of them may raise the output. The mask can be rewritten whole, or changed one bit at a time through set-only and clear-only aliases, so no read-modify-write sequence is needed.

A read-only vector register gives the number of the most urgent request that is both pending and unmasked. Line 0 is the most urgent. A control register holds a global output gate and a source-select bit. After reset the block is in test mode. In test mode the request lines are ignored and software writes the pending register directly to inject interrupts. Once software sets the source-select bit, the block follows the hardware lines, software can only acknowledge pending bits, and the bit stays set until reset.

Register byte offsets: pending `0x00`, mask `0x08`, mask-set `0x10`, mask-clear `0x14`, vector `0x18`, control `0x1C`. Any other offset, and either alias, reads as 0.

Top module: `prio_intc`

## Requirements
- R1: After reset, the pending register, mask register and control register all read 0, the vector reads 0xFFFFFFFF, and `irq` is 0.
- R2: A write to offset 0x08 loads mask bits N-1..0 from the write data. A read of 0x08 returns the mask with bits 31..N as 0.
- R3: A write to offset 0x10 sets each mask bit whose write-data bit is 1. Mask bits whose write-data bit is 0 keep their value.
- R4: A write to offset 0x14 clears each mask bit whose write-data bit is 1. Zero bits, and one bits at positions N and above, change nothing.
- R5: A read of offset 0x18 returns the lowest index i for which pending[i] and mask[i] are both 1. If no such bit exists, it returns 0xFFFFFFFF.
- R6: `irq` is a register. One clock after control bit 0 is 1 and (pending & mask) is nonzero, `irq` is 1. One clock after control bit 0 is 0, `irq` is 0.
- R7: While control bit 1 is 0 (test mode), a write to offset 0x00 loads the pending register from write data bits N-1..0. The `irq_in` lines have no effect on the pending register.
- R8: Writing 1 to control bit 1 selects hardware mode. After that, the bit ignores every write until reset. Control bit 0 stays freely writable.
- R9: In hardware mode, a line found high at a clock edge sets its pending bit. The bit stays set until software writes 1 to that bit at offset 0x00, and the clear only takes effect if the line is low on that edge. Writing 0 bits at offset 0x00 never sets pending bits in this mode.
- R10: Writes to control bits 31..2 are ignored, and those bits read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N | Level-sensitive interrupt request lines |
| bus_addr | input | AW | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Registered interrupt request to the processor |

## Verification
The pending, mask and control registers are visible only through bus reads and through `irq`. A corrupted bit therefore shows up either in the next read of its register or in the vector read, or on `irq` two clock edges after the faulty register update. The mode bit matters most: if it is lost, a write of zero to the control register sends the block back to test mode. If it is stuck, injected requests never appear. Either fault shows in the next pending-register read. A priority fault, such as the wrong bit order or a missing all-ones code, appears only when two or more requests are pending and unmasked, or when none are. For that reason the vector is read with several such patterns.

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int N  = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_in,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  input  logic          bus_wr,
  input  logic          bus_rd,
  output logic [31:0]   bus_rdata,
  output logic          irq
);
  localparam int VW = (N > 1) ? $clog2(N) : 1;
  localparam logic [AW-1:0] A_PEND = AW'(8'h00);
  localparam logic [AW-1:0] A_MASK = AW'(8'h08);
  localparam logic [AW-1:0] A_MSET = AW'(8'h10);
  localparam logic [AW-1:0] A_MCLR = AW'(8'h14);
  localparam logic [AW-1:0] A_VECT = AW'(8'h18);
  localparam logic [AW-1:0] A_CTRL = AW'(8'h1C);

  logic [N-1:0] pend, mask;
  logic         gate_en, hw_mode;
  logic [N-1:0] wbits;
  logic         pend_wr, mask_wr, mset_wr, mclr_wr, ctrl_wr;
  logic [N-1:0] live;
  logic         vfound;
  logic [VW-1:0] vidx;
  logic [31:0]  rd_mux;
  logic         unused_bits;

  assign wbits   = bus_wdata[N-1:0];
  assign pend_wr = bus_wr && bus_addr == A_PEND;
  assign mask_wr = bus_wr && bus_addr == A_MASK;
  assign mset_wr = bus_wr && bus_addr == A_MSET;
  assign mclr_wr = bus_wr && bus_addr == A_MCLR;
  assign ctrl_wr = bus_wr && bus_addr == A_CTRL;
  assign live    = pend & mask;
  assign unused_bits = ^bus_wdata;

  always_comb begin
    vfound = 1'b0;
    vidx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (live[i]) begin
        vfound = 1'b1;
        vidx   = VW'(i);
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (bus_addr)
      A_PEND:  rd_mux = 32'(pend);
      A_MASK:  rd_mux = 32'(mask);
      A_VECT:  rd_mux = vfound ? 32'(vidx) : '1;
      A_CTRL:  rd_mux = {30'b0, hw_mode, gate_en};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
    end else if (hw_mode) begin
      pend <= (pend & ~(pend_wr ? wbits : '0)) | irq_in;
    end else if (pend_wr) begin
      pend <= wbits;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       mask <= '0;
    else if (mask_wr) mask <= wbits;
    else if (mset_wr) mask <= mask | wbits;
    else if (mclr_wr) mask <= mask & ~wbits;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_en <= 1'b0;
      hw_mode <= 1'b0;
    end else if (ctrl_wr) begin
      gate_en <= bus_wdata[0];
      hw_mode <= hw_mode | bus_wdata[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      irq <= gate_en && (|live);
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end
endmodule

module prio_intc_chk #(
  parameter int N  = 8,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_wdata,
  input logic          bus_wr,
  input logic          irq,
  input logic [N-1:0]  pend,
  input logic [N-1:0]  mask,
  input logic          gate_en,
  input logic          hw_mode
);
  logic pend_hit, clr_hit;
  assign pend_hit = bus_wr && bus_addr == AW'(8'h00);
  assign clr_hit  = bus_wr && bus_addr == AW'(8'h14);

  p_clear_alias_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> (mask & $past(bus_wdata[N-1:0])) == '0);

  p_gate_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en |=> !irq);

  p_gate_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && (|(pend & mask))) |=> irq);

  p_test_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_mode && !pend_hit) |=> $stable(pend));

  p_mode_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hw_mode |=> hw_mode);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_mode && !pend_hit) |=> ((pend & $past(pend)) == $past(pend)));
endmodule

bind prio_intc prio_intc_chk #(.N(N), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_wr(bus_wr), .irq(irq), .pend(pend), .mask(mask),
  .gate_en(gate_en), .hw_mode(hw_mode)
);

// File: tb/prio_intc_tb.sv
module prio_intc_tb;
  localparam int N  = 8;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_in = '0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [31:0]   bus_rdata;
  logic          irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_q = 1'b0;

  always #5 clk = ~clk;

  prio_intc #(.N(N), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  always @(posedge clk) rd_q <= bus_rd;

  always @(negedge clk) begin
    if (rd_q && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s: read got %08h expected %08h", t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_addr = AW'(a); bus_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    repeat (2) @(negedge clk);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s: irq got %0b expected %0b", t, irq, e);
    end
  endtask

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
      end
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_irq(1'b0, "R1 irq after reset");
        rd(8'h00, 32'h0, "R1 pending reset");
        rd(8'h08, 32'h0, "R1 mask reset");
        rd(8'h1C, 32'h0, "R1 control reset");
        rd(8'h18, 32'hFFFF_FFFF, "R1 vector reset");

        wr(8'h08, 32'hFFFF_FF0F);
        rd(8'h08, 32'h0000_000F, "R2 mask direct write");
        wr(8'h10, 32'h0000_0030);
        rd(8'h08, 32'h0000_003F, "R3 mask set alias");
        wr(8'h10, 32'h0);
        rd(8'h08, 32'h0000_003F, "R3 set alias zeros");
        wr(8'h14, 32'hFFFF_FF01);
        rd(8'h08, 32'h0000_003E, "R4 clear alias high bits");
        wr(8'h14, 32'h0);
        rd(8'h08, 32'h0000_003E, "R4 clear alias zeros");
        rd(8'h10, 32'h0, "R2 set alias reads zero");

        irq_in = 8'hFF;
        repeat (3) @(negedge clk);
        rd(8'h00, 32'h0, "R7 lines ignored in test mode");
        wr(8'h00, 32'h0000_0024);
        rd(8'h00, 32'h0000_0024, "R7 injected pending");
        rd(8'h18, 32'h0000_0002, "R5 vector lowest of two");
        chk_irq(1'b0, "R6 gate off");
        wr(8'h1C, 32'hFFFF_FFFD);
        rd(8'h1C, 32'h0000_0001, "R10 upper control bits");
        chk_irq(1'b1, "R6 gate on");
        wr(8'h00, 32'h0000_0080);
        rd(8'h18, 32'hFFFF_FFFF, "R5 vector masked only");
        chk_irq(1'b0, "R6 nothing live");

        irq_in = '0;
        wr(8'h1C, 32'h0000_0003);
        rd(8'h1C, 32'h0000_0003, "R8 hardware mode selected");
        wr(8'h00, 32'h0000_0080);
        rd(8'h00, 32'h0, "R9 acknowledge clears");
        wr(8'h1C, 32'h0000_0001);
        rd(8'h1C, 32'h0000_0003, "R8 mode bit holds");
        wr(8'h00, 32'h0000_000F);
        rd(8'h00, 32'h0, "R9 write cannot set in hw mode");

        @(negedge clk); irq_in = 8'h10;
        @(negedge clk); irq_in = '0;
        rd(8'h00, 32'h0000_0010, "R9 pulse captured sticky");
        rd(8'h18, 32'h0000_0004, "R5 vector single");
        chk_irq(1'b1, "R9 irq from line");
        wr(8'h00, 32'h0000_0010);
        rd(8'h00, 32'h0, "R9 acknowledge pulse");
        chk_irq(1'b0, "R9 irq drops after ack");

        irq_in = 8'h0A;
        @(negedge clk);
        wr(8'h00, 32'h0000_0002);
        rd(8'h00, 32'h0000_000A, "R9 ack loses to held line");
        rd(8'h18, 32'h0000_0001, "R5 vector priority");
        wr(8'h1C, 32'h0);
        rd(8'h1C, 32'h0000_0002, "R8 mode survives zero write");
        chk_irq(1'b0, "R6 gate cleared in hw mode");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
          errors++;
          $display("FAIL scoreboard: %0d reads unanswered", exp_q.size());
        end
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule